// File: doc/BRIEF.md
# Fractional-N Synthesizer Serial Register Bank

This block holds the programming state of a fractional-N frequency synthesizer. A host writes 24-bit words over a three-wire serial port made of a serial clock, a data line and a latch strobe. Bits enter most significant first on rising serial-clock edges, and the word is committed to one of four registers when the latch strobe rises. The two least significant bits of the word choose the target: the divider word, the reference/modulus word, the control word or the noise/spur word. The three serial pins are asynchronous to the system clock, so each is resynchronized and edge-detected before use.

Every field is decoded and driven as a dedicated output. The fractional modulus is double-buffered. A reference/modulus write parks the new value in a pending register, and the value reaches the active modulus output only on the next divider write. When the load-control bit is set in a reference/modulus word, the modulus field is sent to a resync-delay register and the pending modulus is left untouched. Derived outputs combine control bits with power-down and fastlock:
- Counter hold is driven by either the counter-reset bit or power-down.
- Charge-pump tristate is driven by either the tristate bit or power-down.
- The effective charge-pump current is forced to full scale under fastlock.
- Lock-detector clear is driven by power-down or by a new channel write.

Top module: `synth_regbank`

## Requirements
- R1: After reset every output is zero.
- R2: Word bits [1:0] select the target register: 00 divider, 01 reference/modulus, 10 control, 11 noise/spur. A write changes only the outputs of the register it addresses.
- R3: Divider word layout: FRAC at bits 13:2, INT at bits 22:14, fastlock at bit 23. These drive `fracVal`, `intVal` and `fastLock`.
- R4: Reference/modulus word layout with load control 0: modulus at 13:2 (into the pending register), R count at 17:14 to `refDiv`, prescaler select at 18 to `prescSel`, output-mux select at 22:20 to `muxSel`, load control at 23. Bit 19 is ignored.
- R5: `modActive` takes the pending modulus on the next divider write and does not change on any other write.
- R6: A reference/modulus word with bit 23 = 1 loads bits 13:2 into `resyncDelay`. The pending modulus is unchanged, and the following divider write activates the earlier pending value. R count, prescaler and mux fields are still taken.
- R7: Control word layout: bit 2 counter reset, 3 charge-pump tristate, 4 power-down (`powerDown`), 5 lock-detect precision (`ldPrecision`), 6 phase-detector polarity (`pdPolarity`), 10:7 charge-pump current, 11 reference doubler (`refDoubler`). Bits 23:12 are ignored.
- R8: `cpCurrent` equals 4'hF while fastlock is 1, and otherwise equals the programmed charge-pump current.
- R9: While power-down is 1, `counterHold`, `cpTriOut` and `lockDetClr` are 1. All stored fields are retained, and new serial words are still accepted.
- R10: `counterHold` is counter reset OR power-down. `cpTriOut` is tristate OR power-down.
- R11: Every divider write produces exactly one single-cycle `chanPgm` pulse, and `lockDetClr` is high in that cycle.
- R12: Data is shifted MSB first. Only the last 24 bits shifted before the latch rising edge form the word. Earlier bits are discarded.
- R13: Noise/spur word bits 23:2 appear on `noiseSpur`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| serLe | input | 1 | Latch strobe; rising edge commits the word |
| intVal | output | 9 | Integer divide value |
| fracVal | output | 12 | Fractional numerator |
| fastLock | output | 1 | Fastlock enable |
| modActive | output | 12 | Modulus in use |
| resyncDelay | output | 12 | Phase-resync delay interval |
| refDiv | output | 4 | Reference divider count |
| prescSel | output | 1 | Prescaler select |
| muxSel | output | 3 | Output multiplexer select |
| counterHold | output | 1 | Counters held in load state |
| cpTriOut | output | 1 | Charge pump tristated |
| powerDown | output | 1 | Power-down request |
| ldPrecision | output | 1 | Lock-detect precision select |
| pdPolarity | output | 1 | Phase-detector polarity |
| cpCurrent | output | 4 | Effective charge-pump current code |
| refDoubler | output | 1 | Reference doubler enable |
| noiseSpur | output | 22 | Noise/spur register contents |
| chanPgm | output | 1 | One-cycle pulse on divider write |
| lockDetClr | output | 1 | Lock detector clear |

## Verification
A bad pending or active modulus can stay hidden for a while. It shows on `modActive` only at the next divider write, so the bench reads `modActive` both before and after every divider write that follows a reference write. A wrong decode or shift alignment reaches a field output a few system cycles after the latch rises; a wrong decode puts data on another register's outputs, while a misaligned shift moves every field. The bench therefore compares the whole output set after each word. A stuck or stretched `chanPgm` is visible within one cycle of the strobe, so pulses and over-long pulses are counted on every clock.

// File: rtl/synth_regs_pkg.sv
package synth_regs_pkg;
  localparam int WORD_W  = 24;
  localparam int INT_W   = 9;
  localparam int FRAC_W  = 12;
  localparam int MOD_W   = 12;
  localparam int RDIV_W  = 4;
  localparam int MUX_W   = 3;
  localparam int CP_W    = 4;
  localparam int NSP_W   = WORD_W - 2;

  // divider word
  localparam int DIV_FRAC_LSB = 2;
  localparam int DIV_INT_LSB  = DIV_FRAC_LSB + FRAC_W;
  localparam int DIV_FL_BIT   = DIV_INT_LSB + INT_W;
  // reference/modulus word
  localparam int REF_MOD_LSB  = 2;
  localparam int REF_R_LSB    = REF_MOD_LSB + MOD_W;
  localparam int REF_PRE_BIT  = REF_R_LSB + RDIV_W;
  localparam int REF_MUX_LSB  = 20;
  localparam int REF_LOAD_BIT = 23;
  // control word
  localparam int CTL_CRST_BIT = 2;
  localparam int CTL_TRI_BIT  = 3;
  localparam int CTL_PD_BIT   = 4;
  localparam int CTL_LDP_BIT  = 5;
  localparam int CTL_POL_BIT  = 6;
  localparam int CTL_CP_LSB   = 7;
  localparam int CTL_DBL_BIT  = CTL_CP_LSB + CP_W;

  typedef enum logic [1:0] {
    ADDR_DIV = 2'b00,
    ADDR_REF = 2'b01,
    ADDR_CTL = 2'b10,
    ADDR_NSP = 2'b11
  } regAddr_t;

  typedef struct packed {
    logic wrDiv;
    logic wrRef;
    logic wrCtl;
    logic wrNsp;
  } wrStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import synth_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLe,
  output wrStrobe_t         strb,
  output logic [WORD_W-1:0] word
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync, dataSync, leSync;
  logic clkPrev, lePrev;
  logic clkRise, leRise;
  logic [WORD_W-1:0] shiftReg;
  regAddr_t addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
      leSync   <= '0;
      clkPrev  <= 1'b0;
      lePrev   <= 1'b0;
    end else begin
      clkSync  <= {clkSync[LAST-1:0], serClk};
      dataSync <= {dataSync[LAST-1:0], serData};
      leSync   <= {leSync[LAST-1:0], serLe};
      clkPrev  <= clkSync[LAST];
      lePrev   <= leSync[LAST];
    end
  end

  assign clkRise = clkSync[LAST] & ~clkPrev;
  assign leRise  = leSync[LAST] & ~lePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shiftReg <= '0;
    else if (clkRise) shiftReg <= {shiftReg[WORD_W-2:0], dataSync[LAST]};
  end

  assign word = shiftReg;
  assign addr = regAddr_t'(shiftReg[1:0]);

  always_comb begin
    strb = '0;
    if (leRise) begin
      unique case (addr)
        ADDR_DIV: strb.wrDiv = 1'b1;
        ADDR_REF: strb.wrRef = 1'b1;
        ADDR_CTL: strb.wrCtl = 1'b1;
        ADDR_NSP: strb.wrNsp = 1'b1;
      endcase
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDiv, strb.wrRef, strb.wrCtl, strb.wrNsp}));

  // R12
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkRise |=> $stable(word));
endmodule

// File: rtl/reg_datapath.sv
module reg_datapath
  import synth_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [WORD_W-1:0] word,
  output logic [INT_W-1:0]  intVal,
  output logic [FRAC_W-1:0] fracVal,
  output logic              fastLock,
  output logic [MOD_W-1:0]  modActive,
  output logic [MOD_W-1:0]  resyncDelay,
  output logic [RDIV_W-1:0] refDiv,
  output logic              prescSel,
  output logic [MUX_W-1:0]  muxSel,
  output logic              counterHold,
  output logic              cpTriOut,
  output logic              powerDown,
  output logic              ldPrecision,
  output logic              pdPolarity,
  output logic [CP_W-1:0]   cpCurrent,
  output logic              refDoubler,
  output logic [NSP_W-1:0]  noiseSpur,
  output logic              chanPgm,
  output logic              lockDetClr
);
  logic [MOD_W-1:0] modPending;
  logic             cntRst, cpTri;
  logic [CP_W-1:0]  cpSet;
  logic             unusedBits;

  assign unusedBits = ^{word[REF_PRE_BIT+1], word[WORD_W-1:CTL_DBL_BIT+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intVal      <= '0;
      fracVal     <= '0;
      fastLock    <= 1'b0;
      modPending  <= '0;
      modActive   <= '0;
      resyncDelay <= '0;
      refDiv      <= '0;
      prescSel    <= 1'b0;
      muxSel      <= '0;
      cntRst      <= 1'b0;
      cpTri       <= 1'b0;
      powerDown   <= 1'b0;
      ldPrecision <= 1'b0;
      pdPolarity  <= 1'b0;
      cpSet       <= '0;
      refDoubler  <= 1'b0;
      noiseSpur   <= '0;
      chanPgm     <= 1'b0;
    end else begin
      chanPgm <= strb.wrDiv;
      if (strb.wrDiv) begin
        fracVal   <= word[DIV_FRAC_LSB +: FRAC_W];
        intVal    <= word[DIV_INT_LSB +: INT_W];
        fastLock  <= word[DIV_FL_BIT];
        modActive <= modPending;
      end
      if (strb.wrRef) begin
        refDiv   <= word[REF_R_LSB +: RDIV_W];
        prescSel <= word[REF_PRE_BIT];
        muxSel   <= word[REF_MUX_LSB +: MUX_W];
        if (word[REF_LOAD_BIT]) resyncDelay <= word[REF_MOD_LSB +: MOD_W];
        else                    modPending  <= word[REF_MOD_LSB +: MOD_W];
      end
      if (strb.wrCtl) begin
        cntRst      <= word[CTL_CRST_BIT];
        cpTri       <= word[CTL_TRI_BIT];
        powerDown   <= word[CTL_PD_BIT];
        ldPrecision <= word[CTL_LDP_BIT];
        pdPolarity  <= word[CTL_POL_BIT];
        cpSet       <= word[CTL_CP_LSB +: CP_W];
        refDoubler  <= word[CTL_DBL_BIT];
      end
      if (strb.wrNsp) noiseSpur <= word[WORD_W-1:2];
    end
  end

  assign cpCurrent   = fastLock ? {CP_W{1'b1}} : cpSet;
  assign counterHold = cntRst | powerDown;
  assign cpTriOut    = cpTri | powerDown;
  assign lockDetClr  = powerDown | chanPgm;

  // R5
  mod_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modActive) |-> $past(strb.wrDiv));

  // R6
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRef && word[REF_LOAD_BIT]) |=> $stable(modPending));

  // R8
  fastlock_cp_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastLock |-> (cpCurrent == {CP_W{1'b1}}));

  // R9
  pwrdn_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> (counterHold && cpTriOut && lockDetClr));

  // R11
  chan_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanPgm |=> !chanPgm);
endmodule

// File: rtl/synth_regbank.sv
module synth_regbank
  import synth_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLe,
  output logic [8:0]  intVal,
  output logic [11:0] fracVal,
  output logic        fastLock,
  output logic [11:0] modActive,
  output logic [11:0] resyncDelay,
  output logic [3:0]  refDiv,
  output logic        prescSel,
  output logic [2:0]  muxSel,
  output logic        counterHold,
  output logic        cpTriOut,
  output logic        powerDown,
  output logic        ldPrecision,
  output logic        pdPolarity,
  output logic [3:0]  cpCurrent,
  output logic        refDoubler,
  output logic [21:0] noiseSpur,
  output logic        chanPgm,
  output logic        lockDetClr
);
  wrStrobe_t         strb;
  logic [WORD_W-1:0] word;

  ssp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLe(serLe), .strb(strb), .word(word)
  );

  reg_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .word(word),
    .intVal(intVal), .fracVal(fracVal), .fastLock(fastLock),
    .modActive(modActive), .resyncDelay(resyncDelay), .refDiv(refDiv),
    .prescSel(prescSel), .muxSel(muxSel), .counterHold(counterHold),
    .cpTriOut(cpTriOut), .powerDown(powerDown), .ldPrecision(ldPrecision),
    .pdPolarity(pdPolarity), .cpCurrent(cpCurrent), .refDoubler(refDoubler),
    .noiseSpur(noiseSpur), .chanPgm(chanPgm), .lockDetClr(lockDetClr)
  );
endmodule

// File: tb/synth_regbank_tb_top.sv
module synth_regbank_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLe = 1'b0;

  logic [8:0]  intVal;
  logic [11:0] fracVal, modActive, resyncDelay;
  logic        fastLock, prescSel, counterHold, cpTriOut, powerDown;
  logic        ldPrecision, pdPolarity, refDoubler, chanPgm, lockDetClr;
  logic [3:0]  refDiv, cpCurrent;
  logic [2:0]  muxSel;
  logic [21:0] noiseSpur;

  always #2 clk = ~clk;

  synth_regbank dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .intVal(intVal), .fracVal(fracVal), .fastLock(fastLock),
    .modActive(modActive), .resyncDelay(resyncDelay), .refDiv(refDiv),
    .prescSel(prescSel), .muxSel(muxSel), .counterHold(counterHold),
    .cpTriOut(cpTriOut), .powerDown(powerDown), .ldPrecision(ldPrecision),
    .pdPolarity(pdPolarity), .cpCurrent(cpCurrent), .refDoubler(refDoubler),
    .noiseSpur(noiseSpur), .chanPgm(chanPgm), .lockDetClr(lockDetClr)
  );

  int nVec = 0, nErr = 0;
  bit finished = 1'b0;

  // model state built from the requirements
  logic [8:0]  mInt;
  logic [11:0] mFrac, mModP, mModA, mRes, mCtl;
  logic        mFl, mPre;
  logic [3:0]  mR;
  logic [2:0]  mMux;
  logic [21:0] mNsp;
  int divWrites = 0;

  // pulse monitor (R11)
  int pulses = 0, longPulses = 0, clrMiss = 0;
  logic prevPgm = 1'b0;
  always @(negedge clk) begin
    if (chanPgm) begin
      pulses++;
      if (prevPgm) longPulses++;
      if (!lockDetClr) clrMiss++;
    end
    prevPgm = chanPgm;
  end

  task automatic chk(string req, string name, logic [31:0] got, logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s %s: got %0h expected %0h", req, name, got, exp);
    end
  endtask

  task automatic checkAll(string req);
    logic [3:0] expCp;
    expCp = mFl ? 4'hF : mCtl[10:7];
    chk(req, "intVal", 32'(intVal), 32'(mInt));
    chk(req, "fracVal", 32'(fracVal), 32'(mFrac));
    chk(req, "fastLock", 32'(fastLock), 32'(mFl));
    chk(req, "modActive", 32'(modActive), 32'(mModA));
    chk(req, "resyncDelay", 32'(resyncDelay), 32'(mRes));
    chk(req, "refDiv", 32'(refDiv), 32'(mR));
    chk(req, "prescSel", 32'(prescSel), 32'(mPre));
    chk(req, "muxSel", 32'(muxSel), 32'(mMux));
    chk(req, "counterHold", 32'(counterHold), 32'(mCtl[2] | mCtl[4]));
    chk(req, "cpTriOut", 32'(cpTriOut), 32'(mCtl[3] | mCtl[4]));
    chk(req, "powerDown", 32'(powerDown), 32'(mCtl[4]));
    chk(req, "ldPrecision", 32'(ldPrecision), 32'(mCtl[5]));
    chk(req, "pdPolarity", 32'(pdPolarity), 32'(mCtl[6]));
    chk(req, "cpCurrent", 32'(cpCurrent), 32'(expCp));
    chk(req, "refDoubler", 32'(refDoubler), 32'(mCtl[11]));
    chk(req, "noiseSpur", 32'(noiseSpur), 32'(mNsp));
    chk(req, "lockDetClr", 32'(lockDetClr), 32'(mCtl[4]));
  endtask

  task automatic shiftBits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i];
      repeat (4) @(posedge clk);
      serClk = 1'b1;
      repeat (4) @(posedge clk);
      serClk = 1'b0;
    end
  endtask

  task automatic latchWord(logic [23:0] w);
    repeat (2) @(posedge clk);
    serLe = 1'b1;
    repeat (4) @(posedge clk);
    serLe = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    unique case (w[1:0])
      2'b00: begin
        mFrac = w[13:2]; mInt = w[22:14]; mFl = w[23]; mModA = mModP;
        divWrites++;
      end
      2'b01: begin
        mR = w[17:14]; mPre = w[18]; mMux = w[22:20];
        if (w[23]) mRes = w[13:2]; else mModP = w[13:2];
      end
      2'b10: mCtl = {w[11:2], 2'b00};
      2'b11: mNsp = w[23:2];
    endcase
  endtask

  task automatic send(logic [23:0] w);
    shiftBits(32'(w), 24);
    latchWord(w);
  endtask

  function automatic logic [23:0] mkDiv(logic fl, logic [8:0] iv, logic [11:0] fr);
    return {fl, iv, fr, 2'b00};
  endfunction
  function automatic logic [23:0] mkRef(logic ld, logic [2:0] mx, logic pre,
                                        logic [3:0] r, logic [11:0] md);
    return {ld, mx, 1'b1, pre, r, md, 2'b01};
  endfunction
  function automatic logic [23:0] mkCtl(logic [11:0] v);
    return {12'hA5C, v[11:2], 2'b10};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  initial begin
    mInt = '0; mFrac = '0; mModP = '0; mModA = '0; mRes = '0; mCtl = '0;
    mFl = 0; mPre = 0; mR = '0; mMux = '0; mNsp = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checkAll("R1");
    chk("R1", "chanPgm", 32'(chanPgm), 0);
    rstN = 1'b1;
    repeat (3) @(posedge clk);

    // R3 divider sweep, R2 other outputs untouched
    for (int k = 0; k < 16; k++) begin
      send(mkDiv(k[0], 9'((k * 37 + 1) % 512), 12'((k * 251 + 7) % 4096)));
      checkAll("R3");
    end

    // R7 walking single bits over the control word
    for (int b = 2; b < 12; b++) begin
      send(mkCtl(12'(1) << b));
      checkAll("R7");
    end
    // R10 combinations of counter reset and tristate without power-down
    send(mkCtl(12'h004)); checkAll("R10");
    send(mkCtl(12'h008)); checkAll("R10");
    send(mkCtl(12'h00C)); checkAll("R10");

    // R8 charge-pump current under both fastlock settings
    for (int f = 0; f < 2; f++) begin
      send(mkDiv(f[0], 9'd138, 12'd30));
      for (int c = 0; c < 16; c++) begin
        send(mkCtl(12'(c << 7)));
        checkAll("R8");
      end
    end

    // R4 / R5 reference fields and modulus double buffering
    for (int m = 0; m < 8; m++) begin
      send(mkRef(1'b0, 3'(m), m[0], 4'(15 - 2 * m), 12'(m * 500 + 3)));
      checkAll("R4");
      checkAll("R5");
      send(mkDiv(1'b0, 9'(m + 31), 12'(m)));
      chk("R5", "modActive after div", 32'(modActive), 32'(m * 500 + 3));
    end

    // R6 load control steers to resync delay; pending kept
    send(mkRef(1'b0, 3'd2, 1'b1, 4'd1, 12'd65));
    send(mkRef(1'b1, 3'd5, 1'b0, 4'd3, 12'd777));
    checkAll("R6");
    chk("R6", "resyncDelay", 32'(resyncDelay), 32'd777);
    send(mkDiv(1'b0, 9'd138, 12'd30));
    chk("R6", "modActive keeps pending", 32'(modActive), 32'd65);
    checkAll("R6");

    // R9 power-down: forced outputs, retention, writes still accepted
    send(mkCtl(12'h010));
    checkAll("R9");
    send(mkDiv(1'b1, 9'd91, 12'd100));
    checkAll("R9");
    send({22'h2AAAAA, 2'b11});
    checkAll("R9");
    send(mkCtl(12'h000));
    checkAll("R9");

    // R13 / R2 noise-spur register sweep
    for (int n = 0; n < 8; n++) begin
      send({22'((n * 22'h05A5A5) ^ 22'h3C0F0F), 2'b11});
      checkAll("R13");
    end

    // R12 extra leading bits discarded, MSB first
    shiftBits(32'hB, 4);
    send(mkDiv(1'b0, 9'h155, 12'hA5A));
    checkAll("R12");
    shiftBits(32'h3F, 6);
    send({22'h15A5A5, 2'b11});
    checkAll("R12");

    // R11 one pulse per divider write, lock clear high with it
    chk("R11", "pulse count", 32'(pulses), 32'(divWrites));
    chk("R11", "stretched pulses", 32'(longPulses), 0);
    chk("R11", "lockDetClr with pulse", 32'(clrMiss), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule